// File: doc/BRIEF.md
# Subcode Serial Stream Receiver

This block takes the six subcode channel bits R to W, one frame at a time, from an upstream disc signal processor. Each frame is announced on a frame-sync line. The block waits a short fixed time after the announcing edge. It then checks that the sync lines still hold the levels the selected handshake expects. If they do, it drives a burst of six read-clock pulses out to the processor and shifts in one data bit per pulse.

When the burst ends, the six bits are presented as one byte with a one-cycle valid strobe. A block-start flag comes with the byte and marks frames whose block-sync line was seen high. A two-bit selector picks among three handshakes, which differ in the frame-sync edge that announces a frame and in the read-clock edge used for sampling. A mute input shuts the interface off.

All timing is counted on the system clock. The qualification delay and the read-clock period are derived from a clock-frequency parameter, so a different crystal only needs a new parameter value. Downstream logic uses the strobed bytes and block-start flags for deinterleaving and decoding; that work is not part of this block.

Top module: `subcode_rx`

## Requirements
- R1: `sel_i` picks the handshake: 2'b00 is handshake A, 2'b10 is handshake B, 2'b11 is handshake C. In A and C a rising edge of `fsync_i` announces a frame. In B a falling edge announces it, and the other edge is ignored.
- R2: In handshake B a burst starts only if `fsync_i` is still low when the qualification delay ends. A frame sync that returns high before then starts no burst. `bsync_i` does not affect qualification in B.
- R3: In handshakes A and C a burst starts only if, when the qualification delay ends, `fsync_i` is high and `bsync_i` is low.
- R4: A burst is exactly six `rclk_o` pulses. Each pulse is high for HALF = SYS_CLK_KHZ/(2*RCLK_KHZ) cycles and then low for HALF cycles, so successive rising edges are 2*HALF cycles apart. `rclk_o` idles low.
- R5: In A and B the data level is taken at each rising edge of `rclk_o`. In C it is taken at each falling edge. The level of `sdata_i` away from the selected edge has no effect on the symbol.
- R6: The byte on `sym_o` holds the first bit received (R) in bit 7, then S, T, U, V, W down to bit 2. Bits 1:0 are zero.
- R7: `sym_valid_o` is high for exactly one cycle after the sixth pulse of each burst, and only then. `sym_o` and `blk_start_o` hold their values until the next strobe.
- R8: `blk_start_o` is 1 when `bsync_i` was high on any cycle from the announcing edge to the end of qualification for that frame, and 0 otherwise.
- R9: While `mute_i` is high, `rclk_o` stays low and no frame is announced, whatever `fsync_i`, `bsync_i` and `sdata_i` do. A burst that is interrupted by mute is dropped and produces no strobe.
- R10: After reset, `rclk_o`, `sym_valid_o`, `blk_start_o` and `sym_o` are all zero.
- R11: With `sel_i` = 2'b01 no frame is ever announced and `rclk_o` never pulses.
- R12: The first rising edge of `rclk_o` comes between QUAL and QUAL+4 cycles after the announcing frame-sync edge reaches the input. QUAL = SYS_CLK_KHZ*QUAL_NS/1e6 cycles, which is 31 at the default values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Handshake selector |
| mute_i | input | 1 | High shuts the interface off |
| fsync_i | input | 1 | Subcode frame sync from the processor |
| bsync_i | input | 1 | Subcode block sync from the processor |
| sdata_i | input | 1 | Serial R to W data from the processor |
| rclk_o | output | 1 | Read clock driven to the processor |
| sym_o | output | 8 | Assembled symbol, R in bit 7 |
| sym_valid_o | output | 1 | One-cycle strobe for a new symbol |
| blk_start_o | output | 1 | Block sync was seen for this symbol's frame |

## Verification
The hardest case to reach from the ports is proving that the sampling edge is the one the handshake selects. A source that holds each bit for a whole read-clock period gives the same bytes for either edge. The bench source therefore drives the correct bit only in a window around the selected edge, in step with the read clock it observes, and drives random levels everywhere else. A byte can then come out right only if sampling happens inside that window. Short frame-sync glitches, block sync held across the check point, and mute raised in mid-burst are driven as directed frames between the randomized ones.

// File: rtl/subrx_pkg.sv
`timescale 1ns/1ps
package subrx_pkg;

  typedef enum logic [1:0] {
    HS_A    = 2'd0,
    HS_B    = 2'd1,
    HS_C    = 2'd2,
    HS_NONE = 2'd3
  } hs_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_QUAL  = 2'd1,
    ST_BURST = 2'd2
  } seq_state_e;

  // Selector decode: 00 -> A, 10 -> B, 11 -> C, 01 -> no handshake.
  function automatic hs_mode_e decode_sel(input logic [1:0] s);
    case (s)
      2'b00:   return HS_A;
      2'b10:   return HS_B;
      2'b11:   return HS_C;
      default: return HS_NONE;
    endcase
  endfunction

  // Qualification delay in system-clock cycles, at least one.
  function automatic int unsigned qual_cycles(input int unsigned khz,
                                              input int unsigned ns);
    int unsigned v;
    v = (khz * ns) / 1000000;
    return (v == 0) ? 1 : v;
  endfunction

  // Half period of the read clock in system-clock cycles, at least one.
  function automatic int unsigned half_cycles(input int unsigned khz,
                                              input int unsigned rclk_khz);
    int unsigned v;
    v = khz / (2 * rclk_khz);
    return (v == 0) ? 1 : v;
  endfunction

endpackage

// File: rtl/subrx_sync.sv
`timescale 1ns/1ps
module subrx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/subrx_seq.sv
`timescale 1ns/1ps
module subrx_seq
  import subrx_pkg::*;
#(
  parameter int Q     = 31,
  parameter int H     = 178,
  parameter int NBITS = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  hs_mode_e mode_i,
  input  logic     mute_i,
  input  logic     fs_i,
  input  logic     bs_i,
  output logic     qual_start_o,
  output logic     burst_start_o,
  output logic     in_burst_o,
  output logic     bit_sample_o,
  output logic     finish_o,
  output logic     rclk_o,
  output logic     blk_seen_o,
  output hs_mode_e mode_q_o
);

  localparam int PER = 2 * H;
  localparam int QW  = $clog2(Q + 1);
  localparam int PW  = $clog2(PER + 1);
  localparam int BW  = $clog2(NBITS + 1);

  seq_state_e      state_q;
  logic [QW-1:0]   qcnt_q;
  logic [PW-1:0]   phase_q;
  logic [BW-1:0]   bit_q;
  hs_mode_e        mode_q;
  logic            fs_prev_q;
  logic            blk_q;

  logic edge_hit, qual_ok, qual_done, last_phase, last_bit;
  logic [PW-1:0] samp_phase;

  always_comb begin
    case (mode_i)
      HS_A, HS_C: edge_hit = fs_i & ~fs_prev_q;
      HS_B:       edge_hit = ~fs_i & fs_prev_q;
      default:    edge_hit = 1'b0;
    endcase
    case (mode_q)
      HS_A, HS_C: qual_ok = fs_i & ~bs_i;
      HS_B:       qual_ok = ~fs_i;
      default:    qual_ok = 1'b0;
    endcase
  end

  assign qual_start_o  = (state_q == ST_IDLE) && edge_hit && !mute_i;
  assign qual_done     = (state_q == ST_QUAL) && (qcnt_q == QW'(Q - 1));
  assign burst_start_o = qual_done && qual_ok && !mute_i;
  assign in_burst_o    = (state_q == ST_BURST);
  assign last_phase    = (phase_q == PW'(PER - 1));
  assign last_bit      = (bit_q == BW'(NBITS - 1));
  assign finish_o      = in_burst_o && last_phase && last_bit && !mute_i;
  assign samp_phase    = (mode_q == HS_C) ? PW'(H) : '0;
  assign bit_sample_o  = in_burst_o && !mute_i && (phase_q == samp_phase);
  assign rclk_o        = in_burst_o && !mute_i && (phase_q < PW'(H));
  assign blk_seen_o    = blk_q;
  assign mode_q_o      = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      qcnt_q    <= '0;
      phase_q   <= '0;
      bit_q     <= '0;
      mode_q    <= HS_NONE;
      fs_prev_q <= 1'b0;
      blk_q     <= 1'b0;
    end else begin
      fs_prev_q <= fs_i;
      case (state_q)
        ST_IDLE: begin
          if (qual_start_o) begin
            state_q <= ST_QUAL;
            qcnt_q  <= '0;
            mode_q  <= mode_i;
            blk_q   <= bs_i;
          end
        end
        ST_QUAL: begin
          if (mute_i) begin
            state_q <= ST_IDLE;
          end else begin
            blk_q <= blk_q | bs_i;
            if (qual_done) begin
              state_q <= burst_start_o ? ST_BURST : ST_IDLE;
              phase_q <= '0;
              bit_q   <= '0;
            end else begin
              qcnt_q <= qcnt_q + 1'b1;
            end
          end
        end
        ST_BURST: begin
          if (mute_i) begin
            state_q <= ST_IDLE;
          end else if (last_phase) begin
            phase_q <= '0;
            if (last_bit) state_q <= ST_IDLE;
            else          bit_q   <= bit_q + 1'b1;
          end else begin
            phase_q <= phase_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/subrx_shift.sv
`timescale 1ns/1ps
module subrx_shift #(
  parameter int NBITS = 6,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_i,
  input  logic             d_i,
  input  logic             finish_i,
  input  logic             blk_i,
  output logic [OUT_W-1:0] sym_o,
  output logic             valid_o,
  output logic             blk_o
);

  localparam int PAD = OUT_W - NBITS;

  logic [NBITS-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      sym_o   <= '0;
      valid_o <= 1'b0;
      blk_o   <= 1'b0;
    end else begin
      if (sample_i) sh_q <= {sh_q[NBITS-2:0], d_i};
      valid_o <= finish_i;
      if (finish_i) begin
        sym_o <= {sh_q, {PAD{1'b0}}};
        blk_o <= blk_i;
      end
    end
  end

endmodule

// File: rtl/subcode_rx.sv
`timescale 1ns/1ps
module subcode_rx
  import subrx_pkg::*;
#(
  parameter int SYS_CLK_KHZ = 14318,
  parameter int QUAL_NS     = 2200,
  parameter int RCLK_KHZ    = 40,
  parameter int SYM_BITS    = 6,
  parameter int OUT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel_i,
  input  logic             mute_i,
  input  logic             fsync_i,
  input  logic             bsync_i,
  input  logic             sdata_i,
  output logic             rclk_o,
  output logic [OUT_W-1:0] sym_o,
  output logic             sym_valid_o,
  output logic             blk_start_o
);

  localparam int QUAL_CYC = int'(qual_cycles(SYS_CLK_KHZ, QUAL_NS));
  localparam int HALF_CYC = int'(half_cycles(SYS_CLK_KHZ, RCLK_KHZ));

  hs_mode_e mode_sel, mode_q;
  logic [2:0] sync_q;
  logic fs_s, bs_s, sd_s;
  logic qual_start, burst_start, in_burst, bit_sample, finish, blk_seen;

  assign mode_sel = decode_sel(sel_i);

  subrx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({fsync_i, bsync_i, sdata_i}),
    .q_o   (sync_q)
  );

  assign {fs_s, bs_s, sd_s} = sync_q;

  subrx_seq #(.Q(QUAL_CYC), .H(HALF_CYC), .NBITS(SYM_BITS)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_i        (mode_sel),
    .mute_i        (mute_i),
    .fs_i          (fs_s),
    .bs_i          (bs_s),
    .qual_start_o  (qual_start),
    .burst_start_o (burst_start),
    .in_burst_o    (in_burst),
    .bit_sample_o  (bit_sample),
    .finish_o      (finish),
    .rclk_o        (rclk_o),
    .blk_seen_o    (blk_seen),
    .mode_q_o      (mode_q)
  );

  subrx_shift #(.NBITS(SYM_BITS), .OUT_W(OUT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (bit_sample),
    .d_i      (sd_s),
    .finish_i (finish),
    .blk_i    (blk_seen),
    .sym_o    (sym_o),
    .valid_o  (sym_valid_o),
    .blk_o    (blk_start_o)
  );

endmodule

// File: rtl/subcode_rx_chk.sv
`timescale 1ns/1ps
module subcode_rx_chk
  import subrx_pkg::*;
#(
  parameter int Q     = 31,
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       sel_i,
  input logic             mute_i,
  input logic             rclk_o,
  input logic [OUT_W-1:0] sym_o,
  input logic             sym_valid_o,
  input logic             qual_start,
  input logic             burst_start,
  input logic             in_burst,
  input logic             bit_sample,
  input hs_mode_e         mode_q
);

  logic [31:0] since_qual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_qual_q <= 32'hFFFF;
    else if (qual_start)                 since_qual_q <= '0;
    else if (since_qual_q != 32'hFFFF)   since_qual_q <= since_qual_q + 1;
  end

  // R9
  mute_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mute_i |-> !rclk_o);

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |=> !sym_valid_o);

  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_o |-> (sym_o[1:0] == 2'b00));

  // R11
  illegal_no_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qual_start |-> (sel_i != 2'b01));

  // R4
  clk_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rclk_o |-> in_burst);

  // R5
  ab_rise_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_sample && mode_q != HS_C) |-> rclk_o);

  // R5
  c_fall_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_sample && mode_q == HS_C) |-> (!rclk_o && $past(rclk_o)));

  // R12
  qual_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |-> (since_qual_q == 32'(Q - 1)));

endmodule

bind subcode_rx subcode_rx_chk #(.Q(QUAL_CYC), .OUT_W(OUT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_i       (sel_i),
  .mute_i      (mute_i),
  .rclk_o      (rclk_o),
  .sym_o       (sym_o),
  .sym_valid_o (sym_valid_o),
  .qual_start  (qual_start),
  .burst_start (burst_start),
  .in_burst    (in_burst),
  .bit_sample  (bit_sample),
  .mode_q      (mode_q)
);

// File: tb/tb_subcode_rx.sv
`timescale 1ns/1ps
module tb_subcode_rx;

  localparam int CLK_PERIOD = 70;
  localparam int KHZ  = 14318;
  localparam int QNS  = 2200;
  localparam int RKHZ = 40;
  localparam int WATCHDOG_CYC = 190000;

  // Bench restatement of the timing rules in R4 and R12.
  function automatic int exp_qual();
    return (KHZ * QNS) / 1000000;
  endfunction
  function automatic int exp_half();
    return KHZ / (2 * RKHZ);
  endfunction
  function automatic logic [7:0] exp_sym(input logic [5:0] b);
    logic [7:0] v;
    for (int i = 0; i < 6; i++) v[7 - i] = b[5 - i];
    v[1:0] = 2'b00;
    return v;
  endfunction

  localparam int Q = 31;
  localparam int H = 178;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic mute = 1'b0, fsync = 1'b0, bsync = 1'b0, sdata = 1'b0;
  logic rclk, sym_valid, blk;
  logic [7:0] sym;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  subcode_rx dut (
    .clk (clk), .rst_n (rst_n), .sel_i (sel), .mute_i (mute),
    .fsync_i (fsync), .bsync_i (bsync), .sdata_i (sdata),
    .rclk_o (rclk), .sym_o (sym), .sym_valid_o (sym_valid),
    .blk_start_o (blk)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Frame results
  int r_rises, r_valids, r_first, r_badper, r_badhigh, r_muteviol;
  logic [7:0] r_sym;
  logic r_blk;

  // bs_mode: 0 none, 1 pulse on the edge, 2 held past the check point
  task automatic run_frame(input logic [1:0] s, input logic [5:0] bits,
                           input int bs_mode, input bit fs_short,
                           input int mute_at);
    bit idle_lvl;
    int c;
    int hi;
    logic pr;
    logic r;
    int total;
    idle_lvl = (s == 2'b10);
    r_rises = 0; r_valids = 0; r_first = -1; r_badper = 0;
    r_badhigh = 0; r_muteviol = 0; r_sym = '0; r_blk = 1'b0;
    sel = s; mute = 1'b0; fsync = idle_lvl; bsync = 1'b0; sdata = bits[5];
    repeat (20) @(negedge clk);
    c = 0; hi = 0; pr = 1'b0;
    total = Q + 12 * H + 40;
    for (int cyc = 0; cyc < total; cyc++) begin
      r = rclk;
      if (mute && r) r_muteviol++;
      c++;
      if (r && !pr) begin
        if (r_rises == 0) r_first = cyc;
        else if (c != 2 * H) r_badper++;
        r_rises++;
        c = 0;
        hi = 0;
      end
      if (r) hi++;
      if (!r && pr && hi != H) r_badhigh++;
      pr = r;
      if (sym_valid) begin
        r_valids++;
        r_sym = sym;
        r_blk = blk;
      end
      if (cyc == 0) fsync = !idle_lvl;
      if (fs_short && cyc == 5) fsync = idle_lvl;
      if (cyc == 60) fsync = idle_lvl;
      case (bs_mode)
        1:       bsync = (cyc < 5);
        2:       bsync = (cyc < Q + 10);
        default: bsync = 1'b0;
      endcase
      if (mute_at >= 0 && cyc >= mute_at) mute = 1'b1;
      // Correct bit only in a window around the selected sampling edge (R5)
      if (s == 2'b11) begin
        if (r_rises >= 1 && r_rises <= 6 && c >= H / 2 && c < H + H / 4)
          sdata = bits[6 - r_rises];
        else
          sdata = 1'($urandom % 2);
      end else begin
        if (r_rises == 0)
          sdata = bits[5];
        else if (c < H / 4)
          sdata = bits[6 - r_rises];
        else if (c >= 2 * H - H / 2 && r_rises < 6)
          sdata = bits[5 - r_rises];
        else
          sdata = 1'($urandom % 2);
      end
      @(negedge clk);
    end
    mute = 1'b0; fsync = idle_lvl; bsync = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic expect_burst(input string req, input logic [5:0] bits,
                              input bit blk_exp);
    chk(r_rises == 6, req, "rclk pulses", r_rises, 6);
    chk(r_valids == 1, "R7", "strobes", r_valids, 1);
    chk(r_sym == exp_sym(bits), "R6", "symbol", r_sym, exp_sym(bits));
    chk(r_blk == blk_exp, "R8", "block flag", r_blk, blk_exp);
    chk(r_badper == 0 && r_badhigh == 0, "R4", "period errors",
        r_badper + r_badhigh, 0);
    chk(r_first >= Q && r_first <= Q + 4, "R12", "first rise delay",
        r_first, Q + 2);
  endtask

  task automatic expect_none(input string req);
    chk(r_rises == 0, req, "rclk pulses", r_rises, 0);
    chk(r_valids == 0, req, "strobes", r_valids, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    chk(exp_qual() == Q && exp_half() == H, "R12", "bench constants",
        exp_qual(), Q);
    repeat (5) @(negedge clk);
    chk(rclk == 1'b0 && sym_valid == 1'b0 && blk == 1'b0 && sym == 8'h00,
        "R10", "outputs in reset", {rclk, sym_valid, blk, sym}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(rclk == 1'b0 && sym_valid == 1'b0 && blk == 1'b0 && sym == 8'h00,
        "R10", "outputs after reset", {rclk, sym_valid, blk, sym}, 0);

    // R1 R5 R6 directed patterns per handshake
    run_frame(2'b00, 6'b100000, 0, 1'b0, -1); expect_burst("R1", 6'b100000, 1'b0);
    run_frame(2'b10, 6'b111111, 0, 1'b0, -1); expect_burst("R1", 6'b111111, 1'b0);
    run_frame(2'b11, 6'b000001, 1, 1'b0, -1); expect_burst("R5", 6'b000001, 1'b1);
    run_frame(2'b00, 6'b000000, 1, 1'b0, -1); expect_burst("R8", 6'b000000, 1'b1);

    // R11 illegal selector
    run_frame(2'b01, 6'b101010, 0, 1'b0, -1); expect_none("R11");
    // R2 short frame sync in B
    run_frame(2'b10, 6'b110011, 0, 1'b1, -1); expect_none("R2");
    // R3 short frame sync in A, block sync held in C
    run_frame(2'b00, 6'b110011, 0, 1'b1, -1); expect_none("R3");
    run_frame(2'b11, 6'b010101, 2, 1'b0, -1); expect_none("R3");
    // R2 block sync held in B does not block the burst
    run_frame(2'b10, 6'b011010, 2, 1'b0, -1); expect_burst("R2", 6'b011010, 1'b1);
    // R9 mute at the announcing edge, then mute in mid-burst
    run_frame(2'b00, 6'b111000, 1, 1'b0, 0); expect_none("R9");
    chk(r_muteviol == 0, "R9", "rclk while muted", r_muteviol, 0);
    run_frame(2'b11, 6'b111000, 0, 1'b0, Q + 3 * H);
    chk(r_valids == 0, "R9", "strobes after mid-burst mute", r_valids, 0);
    chk(r_muteviol == 0, "R9", "rclk while muted", r_muteviol, 0);
    run_frame(2'b11, 6'b100110, 0, 1'b0, -1); expect_burst("R9", 6'b100110, 1'b0);

    // Randomized legal frames
    for (int n = 0; n < 22; n++) begin
      logic [1:0] s;
      logic [5:0] b;
      int bm;
      case ($urandom % 3)
        0:       s = 2'b00;
        1:       s = 2'b10;
        default: s = 2'b11;
      endcase
      b  = 6'($urandom);
      bm = (s == 2'b10) ? int'($urandom % 3) : int'($urandom % 2);
      run_frame(s, b, bm, 1'b0, -1);
      expect_burst((s == 2'b11) ? "R5" : "R1", b, bm != 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d",
               WATCHDOG_CYC, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule